// File: doc/BRIEF.md
# UART Interrupt Priority and Identification

This block arbitrates the interrupt sources of a 16550-style serial controller. Five sources compete for one interrupt line: receiver line errors, character timeout, receive data available, transmit holding register empty, and modem status change. Each source is gated by its enable bit, and the enables are held in a four-bit enable register inside the block. The block picks the highest-priority active source every clock. It registers the matching identification code into an 8-bit identification byte and drives the interrupt line from the same register.

The holding-empty source has a pending flag of its own, kept in the block. A strobe from the transmitter sets it when the holding register drains. A write to the holding register clears it. A read of the identification byte clears it, but only while that byte reports holding-empty. Toggling the holding-empty enable re-arms it from the current holding-empty status. Baud generation, serial shifting and FIFO storage are outside the block; their status arrives as inputs.

Top module: `uart_irq_arbiter`

## Requirements
- R1: After reset, `iir_out` is 0x01, `irq` is 0, `ier_out` is 0 and the holding-empty pending flag is clear.
- R2: When several sources are active, the reported source is chosen in this order, highest first: line error, character timeout, receive data, holding empty, modem status.
- R3: The low nibble of `iir_out` is 0x1 when no source is active. It is 0x6 for line error, 0xC for timeout, 0x4 for receive data, 0x2 for holding empty and 0x0 for modem status.
- R4: The line error source is active when enable bit 2 is set and any of `lsr` bits 4..1 is set. `lsr` bit 0 (data ready) and bit 5 (holding empty) never raise it.
- R5: The character timeout source is active when `timeout_pend` is 1 and enable bit 0 (receive data enable) is set. It has no enable of its own.
- R6: The receive data source needs enable bit 0 and `lsr` bit 0. With `fifo_en` at 1 it also needs `rx_count >= rx_trig`. With `fifo_en` at 0, data ready alone is enough.
- R7: A read strobe `iir_rd` in a cycle where `iir_out[3:0]` is 0x2 clears the holding-empty pending flag. A read while any other code is reported leaves the flag unchanged.
- R8: A write to the enable register that changes bit 1 sets the pending flag to (new bit 1 AND `lsr` bit 5), and this overrides every other update in that cycle. A write that leaves bit 1 unchanged does not alter the flag.
- R9: `thre_set` sets the pending flag. `thr_wr` clears it. When a set and a clear (write or qualifying read) occur in the same cycle, the clear wins.
- R10: `iir_out[7:6]` read 2'b11 when `fifo_en` was 1 at the last edge, otherwise 2'b00. `iir_out[5:4]` are always 0.
- R11: Only bits 3..0 of `ier_wdata` are stored. `ier_out` shows them and the upper bits are dropped.
- R12: `iir_out` and `irq` are registered. They reflect inputs and state of the previous clock edge, and `irq` is 1 exactly when `iir_out[3:0]` is not 0x1.
- R13: The modem status source is active when enable bit 3 is set and any bit of `msr_delta` is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ier_wr | input | 1 | Write strobe for the enable register |
| ier_wdata | input | 8 | Write data for the enable register |
| thr_wr | input | 1 | Write strobe of the transmit holding register |
| iir_rd | input | 1 | Read strobe of the identification byte |
| thre_set | input | 1 | Pulse: holding register has just become empty |
| fifo_en | input | 1 | FIFOs enabled |
| lsr | input | 6 | Line status: bit0 data ready, bits4..1 error flags, bit5 holding empty |
| rx_count | input | CNT_W | Receive FIFO fill count |
| rx_trig | input | CNT_W | Receive FIFO trigger level |
| timeout_pend | input | 1 | Character timeout pending |
| msr_delta | input | 4 | Modem status change bits |
| irq | output | 1 | Interrupt line |
| iir_out | output | 8 | Identification byte |
| ier_out | output | 4 | Enable register contents |

## Verification
The collision of interest is between the holding-empty flag's own updates: a read that clears it, a holding-register write, a set pulse from the transmitter, and an enable toggle that re-arms it can all land in one cycle. The bench drives these together, both in directed steps (set with write, read while another code is shown, toggling and non-toggling enable writes) and in a long pseudo-random run where each strobe fires independently. A behavioural model applies the stated precedence and is compared against the identification byte, the interrupt line and the enable register after every clock. A wrong winner in a collision therefore shows up as a mismatched code one or two cycles later.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;

  localparam int NSRC = 5;

  // source slot index, lowest index wins
  localparam int SLOT_LINE  = 0;
  localparam int SLOT_TMO   = 1;
  localparam int SLOT_RXD   = 2;
  localparam int SLOT_THRE  = 3;
  localparam int SLOT_MODEM = 4;

  localparam logic [3:0] ID_MODEM = 4'h0;
  localparam logic [3:0] ID_NONE  = 4'h1;
  localparam logic [3:0] ID_THRE  = 4'h2;
  localparam logic [3:0] ID_RXD   = 4'h4;
  localparam logic [3:0] ID_LINE  = 4'h6;
  localparam logic [3:0] ID_TMO   = 4'hC;

  // enable register bit positions
  localparam int EN_RXD   = 0;
  localparam int EN_THRE  = 1;
  localparam int EN_LINE  = 2;
  localparam int EN_MODEM = 3;

  // line status bit positions
  localparam int LS_DR   = 0;
  localparam int LS_THRE = 5;
  localparam logic [5:0] LS_ERR_MASK = 6'h1E;

  // keep the first requesting slot only
  function automatic logic [NSRC-1:0] first_grant(input logic [NSRC-1:0] req);
    logic [NSRC-1:0] g;
    logic taken;
    g = '0;
    taken = 1'b0;
    for (int i = 0; i < NSRC; i++) begin
      if (req[i] && !taken) begin
        g[i]  = 1'b1;
        taken = 1'b1;
      end
    end
    return g;
  endfunction

  function automatic logic [3:0] id_of(input logic [NSRC-1:0] g);
    logic [3:0] id;
    id = ID_NONE;
    if (g[SLOT_LINE])       id = ID_LINE;
    else if (g[SLOT_TMO])   id = ID_TMO;
    else if (g[SLOT_RXD])   id = ID_RXD;
    else if (g[SLOT_THRE])  id = ID_THRE;
    else if (g[SLOT_MODEM]) id = ID_MODEM;
    return id;
  endfunction

  // receive level qualifier
  function automatic logic rx_level_ok(input logic fifo_on,
                                       input logic [15:0] cnt,
                                       input logic [15:0] trig);
    return !fifo_on || (cnt >= trig);
  endfunction

endpackage

// File: rtl/uart_irq_enable.sv
module uart_irq_enable
  import uart_irq_pkg::*;
#(
  parameter int EN_W = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ier_wr,
  input  logic [7:0]      ier_wdata,
  input  logic            thr_wr,
  input  logic            iir_rd,
  input  logic            reported_thre,
  input  logic            thre_set,
  input  logic            thr_empty,
  output logic [EN_W-1:0] ier_q,
  output logic            thre_pend
);

  logic thri_toggle;
  logic rd_clear;
  logic pend_next;

  assign thri_toggle = ier_wr && (ier_q[EN_THRE] != ier_wdata[EN_THRE]);
  assign rd_clear    = iir_rd && reported_thre;

  always_comb begin
    pend_next = thre_pend;
    if (thre_set)              pend_next = 1'b1;
    if (rd_clear || thr_wr)    pend_next = 1'b0;
    if (thri_toggle)           pend_next = ier_wdata[EN_THRE] && thr_empty;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ier_q     <= '0;
      thre_pend <= 1'b0;
    end else begin
      if (ier_wr) ier_q <= ier_wdata[EN_W-1:0];
      thre_pend <= pend_next;
    end
  end

  // R11
  ier_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ier_wr && (ier_wdata[7:4] != 4'h0) |=> ier_q == $past(ier_wdata[EN_W-1:0]));

  // R9
  thr_write_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    thr_wr && !thri_toggle |=> !thre_pend);

  // R9
  thre_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    thre_set && !thr_wr && !rd_clear && !thri_toggle |=> thre_pend);

  // R7
  read_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_clear && !thri_toggle |=> !thre_pend);

  // R8
  rearm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    thri_toggle |=> thre_pend == $past(ier_wdata[EN_THRE] && thr_empty));

endmodule

// File: rtl/uart_irq_sources.sv
module uart_irq_sources
  import uart_irq_pkg::*;
#(
  parameter int CNT_W = 5,
  parameter int EN_W  = 4
) (
  input  logic [EN_W-1:0]  ier_q,
  input  logic [5:0]       lsr,
  input  logic             fifo_en,
  input  logic [CNT_W-1:0] rx_count,
  input  logic [CNT_W-1:0] rx_trig,
  input  logic             timeout_pend,
  input  logic             thre_pend,
  input  logic [3:0]       msr_delta,
  output logic [NSRC-1:0]  req
);

  logic line_err;
  logic rx_level;

  assign line_err = |(lsr & LS_ERR_MASK);
  assign rx_level = rx_level_ok(fifo_en, 16'(rx_count), 16'(rx_trig));

  assign req[SLOT_LINE]  = ier_q[EN_LINE]  && line_err;
  assign req[SLOT_TMO]   = ier_q[EN_RXD]   && timeout_pend;
  assign req[SLOT_RXD]   = ier_q[EN_RXD]   && lsr[LS_DR] && rx_level;
  assign req[SLOT_THRE]  = ier_q[EN_THRE]  && thre_pend;
  assign req[SLOT_MODEM] = ier_q[EN_MODEM] && (|msr_delta);

endmodule

// File: rtl/uart_irq_prio.sv
module uart_irq_prio
  import uart_irq_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] req,
  input  logic            fifo_en,
  output logic [7:0]      iir_q,
  output logic            irq_q
);

  logic [NSRC-1:0] grant;
  logic [3:0]      id_now;

  assign grant  = first_grant(req);
  assign id_now = id_of(grant);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      iir_q <= {4'h0, ID_NONE};
      irq_q <= 1'b0;
    end else begin
      iir_q <= {{2{fifo_en}}, 2'b00, id_now};
      irq_q <= (id_now != ID_NONE);
    end
  end

  // R2
  line_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req[SLOT_LINE] |=> iir_q[3:0] == ID_LINE);

  // R2
  modem_lowest_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req[SLOT_MODEM] && (req[SLOT_THRE:SLOT_LINE] == '0) |=> iir_q[3:0] == ID_MODEM);

  // R3
  idle_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req == '0 |=> iir_q[3:0] == ID_NONE);

  // R12
  irq_matches_id_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q == (iir_q[3:0] != ID_NONE));

  // R10
  fifo_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> iir_q[7:4] == {{2{$past(fifo_en)}}, 2'b00});

endmodule

// File: rtl/uart_irq_arbiter.sv
module uart_irq_arbiter
  import uart_irq_pkg::*;
#(
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ier_wr,
  input  logic [7:0]       ier_wdata,
  input  logic             thr_wr,
  input  logic             iir_rd,
  input  logic             thre_set,
  input  logic             fifo_en,
  input  logic [5:0]       lsr,
  input  logic [CNT_W-1:0] rx_count,
  input  logic [CNT_W-1:0] rx_trig,
  input  logic             timeout_pend,
  input  logic [3:0]       msr_delta,
  output logic             irq,
  output logic [7:0]       iir_out,
  output logic [3:0]       ier_out
);

  localparam int EN_W = 4;

  logic [EN_W-1:0] ier_q;
  logic            thre_pend;
  logic [NSRC-1:0] req;
  logic [7:0]      iir_q;
  logic            irq_q;
  logic            reported_thre;

  assign reported_thre = (iir_q[3:0] == ID_THRE);

  uart_irq_enable #(.EN_W(EN_W)) u_enable (
    .clk           (clk),
    .rst_n         (rst_n),
    .ier_wr        (ier_wr),
    .ier_wdata     (ier_wdata),
    .thr_wr        (thr_wr),
    .iir_rd        (iir_rd),
    .reported_thre (reported_thre),
    .thre_set      (thre_set),
    .thr_empty     (lsr[LS_THRE]),
    .ier_q         (ier_q),
    .thre_pend     (thre_pend)
  );

  uart_irq_sources #(.CNT_W(CNT_W), .EN_W(EN_W)) u_sources (
    .ier_q        (ier_q),
    .lsr          (lsr),
    .fifo_en      (fifo_en),
    .rx_count     (rx_count),
    .rx_trig      (rx_trig),
    .timeout_pend (timeout_pend),
    .thre_pend    (thre_pend),
    .msr_delta    (msr_delta),
    .req          (req)
  );

  uart_irq_prio u_prio (
    .clk     (clk),
    .rst_n   (rst_n),
    .req     (req),
    .fifo_en (fifo_en),
    .iir_q   (iir_q),
    .irq_q   (irq_q)
  );

  assign irq     = irq_q;
  assign iir_out = iir_q;
  assign ier_out = ier_q;

endmodule

// File: tb/uart_irq_arbiter_test.sv
module uart_irq_arbiter_test;

  localparam int CLK_P = 10;
  localparam int CNT_W = 5;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             ier_wr = 1'b0;
  logic [7:0]       ier_wdata = 8'h00;
  logic             thr_wr = 1'b0;
  logic             iir_rd = 1'b0;
  logic             thre_set = 1'b0;
  logic             fifo_en = 1'b0;
  logic [5:0]       lsr = 6'h00;
  logic [CNT_W-1:0] rx_count = '0;
  logic [CNT_W-1:0] rx_trig = '0;
  logic             timeout_pend = 1'b0;
  logic [3:0]       msr_delta = 4'h0;
  logic             irq;
  logic [7:0]       iir_out;
  logic [3:0]       ier_out;

  int checks = 0;
  int errors = 0;
  bit finished = 0;
  string cur_req = "R1";

  // reference state
  int m_ier, m_pend, m_iir, m_irq;

  always #(CLK_P/2) clk = ~clk;

  uart_irq_arbiter #(.CNT_W(CNT_W)) uut (
    .clk(clk), .rst_n(rst_n), .ier_wr(ier_wr), .ier_wdata(ier_wdata),
    .thr_wr(thr_wr), .iir_rd(iir_rd), .thre_set(thre_set), .fifo_en(fifo_en),
    .lsr(lsr), .rx_count(rx_count), .rx_trig(rx_trig),
    .timeout_pend(timeout_pend), .msr_delta(msr_delta),
    .irq(irq), .iir_out(iir_out), .ier_out(ier_out)
  );

  // behavioural reference, one update per edge
  always @(posedge clk or negedge rst_n) begin
    int id, np, wd;
    if (!rst_n) begin
      m_ier = 0; m_pend = 0; m_iir = 1; m_irq = 0;
    end else begin
      wd = int'(ier_wdata);
      if ((m_ier & 4) != 0 && (int'(lsr) & 'h1E) != 0)                       id = 6;
      else if ((m_ier & 1) != 0 && timeout_pend)                             id = 12;
      else if ((m_ier & 1) != 0 && lsr[0] &&
               (!fifo_en || int'(rx_count) >= int'(rx_trig)))                id = 4;
      else if ((m_ier & 2) != 0 && m_pend != 0)                              id = 2;
      else if ((m_ier & 8) != 0 && msr_delta != 0)                           id = 0;
      else                                                                   id = 1;
      np = m_pend;
      if (thre_set) np = 1;
      if (iir_rd && (m_iir % 16) == 2) np = 0;
      if (thr_wr) np = 0;
      if (ier_wr && (((m_ier ^ wd) & 2) != 0)) np = ((wd & 2) != 0 && lsr[5]) ? 1 : 0;
      if (ier_wr) m_ier = wd % 16;
      m_pend = np;
      m_iir = (fifo_en ? 'hC0 : 0) + id;
      m_irq = (id != 1) ? 1 : 0;
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare_model();
    check(int'(iir_out) == m_iir, cur_req, int'(iir_out), m_iir);
    check(int'(irq) == m_irq, cur_req, int'(irq), m_irq);
    check(int'(ier_out) == m_ier, cur_req, int'(ier_out), m_ier);
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    ier_wr = 1'b0; thr_wr = 1'b0; iir_rd = 1'b0; thre_set = 1'b0;
    compare_model();
  endtask

  task automatic wr_ier(input logic [7:0] v);
    ier_wr = 1'b1; ier_wdata = v; tick();
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(CLK_P * 150000);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [15:0] lf;
    repeat (3) @(negedge clk);
    // R1 reset state
    cur_req = "R1";
    check(iir_out == 8'h01, "R1", int'(iir_out), 'h01);
    check(irq == 1'b0, "R1", int'(irq), 0);
    check(ier_out == 4'h0, "R1", int'(ier_out), 0);
    rst_n = 1'b1;
    tick();

    // R11 upper enable bits dropped
    cur_req = "R11";
    wr_ier(8'hF8);
    check(ier_out == 4'h8, "R11", int'(ier_out), 8);

    // R13 modem source, R12 one-cycle latency
    cur_req = "R13";
    msr_delta = 4'b0100;
    #1;
    check(irq == 1'b0, "R12", int'(irq), 0);
    @(negedge clk);
    check(iir_out[3:0] == 4'h0, "R13", int'(iir_out[3:0]), 0);
    check(irq == 1'b1, "R12", int'(irq), 1);
    tick();

    // R8 re-arm on enable toggle, R2 holding empty beats modem
    cur_req = "R8";
    lsr = 6'h20;
    wr_ier(8'h0A);
    tick();
    check(iir_out[3:0] == 4'h2, "R8", int'(iir_out[3:0]), 2);

    // R7 read while holding-empty reported clears it
    cur_req = "R7";
    iir_rd = 1'b1; tick();
    tick();
    check(iir_out[3:0] == 4'h0, "R7", int'(iir_out[3:0]), 0);

    // R9 set pulse, then set with write in same cycle
    cur_req = "R9";
    thre_set = 1'b1; tick();
    tick();
    check(iir_out[3:0] == 4'h2, "R9", int'(iir_out[3:0]), 2);
    thre_set = 1'b1; thr_wr = 1'b1; tick();
    tick();
    check(iir_out[3:0] == 4'h0, "R9", int'(iir_out[3:0]), 0);

    // R8 toggle with holding register busy, then write without change
    cur_req = "R8";
    wr_ier(8'h08);
    lsr = 6'h00;
    wr_ier(8'h0A);
    lsr = 6'h20;
    wr_ier(8'h0A);
    tick();
    check(iir_out[3:0] == 4'h0, "R8", int'(iir_out[3:0]), 0);

    // R4 line errors, data ready alone does not count
    cur_req = "R4";
    msr_delta = 4'h0;
    wr_ier(8'h04);
    lsr = 6'h02; tick(); tick();
    check(iir_out[3:0] == 4'h6, "R4", int'(iir_out[3:0]), 6);
    lsr = 6'h21; tick(); tick();
    check(iir_out[3:0] == 4'h1, "R4", int'(iir_out[3:0]), 1);

    // R5 timeout gated by receive data enable
    cur_req = "R5";
    lsr = 6'h00; timeout_pend = 1'b1;
    tick(); tick();
    check(iir_out[3:0] == 4'h1, "R5", int'(iir_out[3:0]), 1);
    wr_ier(8'h01); tick();
    check(iir_out[3:0] == 4'hC, "R5", int'(iir_out[3:0]), 'hC);
    cur_req = "R2";
    wr_ier(8'h05); lsr = 6'h10; tick(); tick();
    check(iir_out[3:0] == 4'h6, "R2", int'(iir_out[3:0]), 6);

    // R6 trigger level, R10 FIFO indication
    cur_req = "R6";
    timeout_pend = 1'b0; lsr = 6'h01; wr_ier(8'h01);
    fifo_en = 1'b1; rx_trig = 5'd8; rx_count = 5'd7; tick(); tick();
    check(iir_out == 8'hC1, "R10", int'(iir_out), 'hC1);
    rx_count = 5'd8; tick();
    check(iir_out[3:0] == 4'h4, "R6", int'(iir_out[3:0]), 4);
    fifo_en = 1'b0; rx_count = 5'd0; tick();
    check(iir_out == 8'h04, "R6", int'(iir_out), 4);

    // R7 read while another code shown leaves flag alone
    cur_req = "R7";
    lsr = 6'h22; wr_ier(8'h06); tick();
    check(iir_out[3:0] == 4'h6, "R7", int'(iir_out[3:0]), 6);
    iir_rd = 1'b1; tick();
    lsr = 6'h20; tick(); tick();
    check(iir_out[3:0] == 4'h2, "R7", int'(iir_out[3:0]), 2);

    // R3 mixed random traffic against the model, including collisions
    cur_req = "R3";
    lf = 16'hACE1;
    for (int i = 0; i < 2000; i++) begin
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      lsr          = lf[5:0] & {lf[9], 5'h1F} & {1'b1, {4{lf[14]}}, 1'b1};
      timeout_pend = lf[6] & lf[11];
      msr_delta    = lf[3:0] & {4{lf[12]}};
      fifo_en      = lf[7];
      rx_count     = lf[12:8];
      rx_trig      = {1'b0, lf[15:12]};
      thre_set     = lf[2] & lf[8];
      thr_wr       = lf[4] & lf[15] & lf[1];
      iir_rd       = lf[10];
      ier_wr       = lf[13] & lf[0];
      ier_wdata    = {lf[7:4], lf[11:8]};
      tick();
    end

    finish_run();
  end

endmodule